// File: doc/BRIEF.md
# I2C Two-Channel Bus Selector

This block is an I2C target that lets a host connect one of two downstream bus channels and find out which channel is raising an interrupt. The host writes a small selection value. The block turns it into two channel-enable outputs, and the enable outputs change only when the bus goes idle. The actual switching of the downstream clock and data pairs is done elsewhere; this block only produces the enable signals.

SCL and SDA arrive as plain inputs. They are sampled and synchronized in the system clock domain. SDA is driven through an open-drain enable: when `sda_oe` is 1 the line is pulled low. Two active-low interrupt inputs are merged into one active-low interrupt output. Their live state is also returned in the byte the host reads back, so the host can tell which channel needs service.

Top module: `i2c_chan_sel`

## Requirements
- R1: The block answers the 7-bit address {ADDR_HI, addr_pins[2:0]}, where ADDR_HI defaults to 4'b1110. Bit 0 of the address byte is the direction: 1 means read and 0 means write. A matching address is acknowledged by `sda_oe`=1 during the ninth SCL clock.
- R2: A non-matching address is not acknowledged. The block then keeps `sda_oe`=0 and leaves the stored value unchanged until the next START or STOP.
- R3: Every data byte of a write transaction is acknowledged, and its low four bits are stored. When several bytes are written, the last one is the value that remains.
- R4: Decoding of the stored value: if bit 2 is 0, no channel is enabled. If bit 2 is 1, bit 0 = 0 enables channel 0 (`ch_en`=2'b01) and bit 0 = 1 enables channel 1 (`ch_en`=2'b10). Bit 1 has no effect, and at most one enable is high.
- R5: A new stored value reaches `ch_en` only after a STOP is detected. Data bytes and a repeated START leave `ch_en` unchanged.
- R6: A read returns {2'b00, ~irq_n_i[1], ~irq_n_i[0], stored[3:0]}. The input state is captured when the byte is loaded, at the SCL fall that ends the preceding acknowledge.
- R7: `irq_n_o` is 0 whenever either bit of `irq_n_i` is 0, whichever channel is enabled, and 1 only when both inputs are 1.
- R8: After reset the stored value is 0, `ch_en` is 2'b00 and `sda_oe` is 0.
- R9: A NACK from the host after a read byte makes the block release SDA and stay quiet until the next START or STOP. An ACK makes it send another byte.
- R10: A repeated START restarts address reception, and the stored value written before it is kept.
- R11: `sda_oe` rises only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as observed |
| sda_i | input | 1 | Bus data line as observed |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 3 | Low three bits of the target address |
| irq_n_i | input | 2 | Active-low interrupt inputs, bit n for channel n |
| irq_n_o | output | 1 | Active-low merged interrupt |
| ch_en | output | 2 | Channel enables, bit n for channel n |

## Verification
An interrupt input can change in the same cycle that a STOP hands the stored selection to `ch_en`. These are two independent paths: the combinational interrupt merge and the registered enable update. The bench provokes the overlap by pulling an interrupt input low at the very moment SDA rises to form the STOP. It judges the result by checking, after the STOP, that `irq_n_o` is low and that `ch_en` holds the newly written selection, so neither event is lost or delayed by the other.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int NCH     = 2;
  localparam int CTRL_W  = 4;
  localparam int PIN_W   = 3;
  localparam int HI_W    = BYTE_W - 1 - PIN_W;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AWAIT, S_ACK, S_WR, S_RD, S_RACK, S_RNEXT, S_SKIP
  } tgt_state_t;

  // selection nibble -> one-hot-or-zero enables
  function automatic logic [NCH-1:0] sel_decode(input logic [CTRL_W-1:0] v);
    logic [NCH-1:0] r;
    r = '0;
    if (v[2]) r[v[0]] = 1'b1;
    return r;
  endfunction

  // byte returned to the host on a read
  function automatic logic [BYTE_W-1:0] rd_image(input logic [NCH-1:0] flags,
                                                 input logic [CTRL_W-1:0] v);
    return {{(BYTE_W-NCH-CTRL_W){1'b0}}, flags, v};
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-2:0] a,
                                    input logic [HI_W-1:0] hi,
                                    input logic [PIN_W-1:0] pins);
    return a == {hi, pins};
  endfunction
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/chsel_target.sv
module chsel_target
  import chsel_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 4'b1110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [CTRL_W-1:0] wr_nib,
  output logic              skip_st
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tgt_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] txsh;
  logic              rw;
  logic [BYTE_W-1:0] byte_in;
  logic              bus_evt;

  assign byte_in = {shreg, sda_s};
  assign bus_evt = start_evt | stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      shreg <= '0;
      txsh  <= '0;
      rw    <= 1'b0;
    end else if (start_evt) begin
      st  <= S_ADDR;
      cnt <= '0;
    end else if (stop_evt) begin
      st  <= S_IDLE;
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          shreg <= byte_in[BYTE_W-2:0];
          if (cnt == LAST) begin
            cnt <= '0;
            if (addr_hit(byte_in[BYTE_W-1:1], ADDR_HI, addr_pins)) begin
              rw <= byte_in[0];
              st <= S_AWAIT;
            end else begin
              st <= S_SKIP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WR: if (scl_rise) begin
          shreg <= byte_in[BYTE_W-2:0];
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_AWAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_AWAIT: if (scl_fall) st <= S_ACK;
        S_ACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            txsh <= rd_byte;
            st   <= S_RD;
          end else begin
            st <= S_WR;
          end
        end
        S_RD: if (scl_fall) begin
          if (cnt == LAST) begin
            st <= S_RACK;
          end else begin
            txsh <= {txsh[BYTE_W-2:0], 1'b0};
            cnt  <= cnt + 1'b1;
          end
        end
        S_RACK: if (scl_rise) st <= sda_s ? S_SKIP : S_RNEXT;
        S_RNEXT: if (scl_fall) begin
          txsh <= rd_byte;
          cnt  <= '0;
          st   <= S_RD;
        end
        default: ;
      endcase
    end
  end

  assign wr_stb  = (st == S_WR) & scl_rise & (cnt == LAST) & ~bus_evt;
  assign wr_nib  = byte_in[CTRL_W-1:0];
  assign sda_oe  = (st == S_ACK) | ((st == S_RD) & ~txsh[BYTE_W-1]);
  assign skip_st = (st == S_SKIP);
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
  import chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CTRL_W-1:0] wr_nib,
  input  logic              stop_evt,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NCH-1:0]    ch_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ch_en  <= '0;
    end else begin
      if (wr_stb)   ctrl_q <= wr_nib;
      if (stop_evt) ch_en  <= sel_decode(ctrl_q);
    end
  end
endmodule

// File: rtl/chsel_irq.sv
module chsel_irq
  import chsel_pkg::*;
(
  input  logic [NCH-1:0] irq_n_i,
  output logic [NCH-1:0] flags,
  output logic           irq_n_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    assign flags[i] = ~irq_n_i[i];
  end
  assign irq_n_o = ~|flags;
endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
  import chsel_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI     = 4'b1110,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [PIN_W-1:0] addr_pins,
  input  logic [NCH-1:0]   irq_n_i,
  output logic             irq_n_o,
  output logic [NCH-1:0]   ch_en
);
  logic scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic wr_stb, skip_st;
  logic [CTRL_W-1:0] wr_nib, ctrl_q;
  logic [NCH-1:0]    flags;
  logic [BYTE_W-1:0] rd_byte;

  chsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  chsel_target #(.ADDR_HI(ADDR_HI)) u_tgt (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .start_evt(start_evt),
    .stop_evt(stop_evt), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .addr_pins(addr_pins), .rd_byte(rd_byte), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_nib(wr_nib), .skip_st(skip_st)
  );

  chsel_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_nib(wr_nib),
    .stop_evt(stop_evt), .ctrl_q(ctrl_q), .ch_en(ch_en)
  );

  chsel_irq u_irq (
    .irq_n_i(irq_n_i), .flags(flags), .irq_n_o(irq_n_o)
  );

  assign rd_byte = rd_image(flags, ctrl_q);
endmodule

// File: rtl/chsel_chk.sv
module chsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [1:0] ch_en,
  input logic [1:0] irq_n_i,
  input logic       irq_n_o,
  input logic       stop_evt,
  input logic       skip_st,
  input logic       scl_s
);
  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en)); // R4
  AST_EN_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en != $past(ch_en)) |-> $past(stop_evt)); // R5
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_i != 2'b11) |-> !irq_n_o); // R7
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_i == 2'b11) |-> irq_n_o); // R7
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    skip_st |-> !sda_oe); // R2
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R11
endmodule

bind i2c_chan_sel chsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ch_en(ch_en),
  .irq_n_i(irq_n_i), .irq_n_o(irq_n_o), .stop_evt(stop_evt),
  .skip_st(skip_st), .scl_s(scl_s)
);

// File: tb/i2c_chan_sel_bench.sv
module i2c_chan_sel_bench;
  localparam int CLK_P = 10;
  localparam int HP    = 12 * CLK_P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic [1:0] irq_n = 2'b11;
  logic sda_oe, irq_n_o;
  logic [1:0] ch_en;
  logic sda_line;
  int checks = 0;
  int errors = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_P/2) clk = ~clk;

  i2c_chan_sel u_i2c_chan_sel (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(pins), .irq_n_i(irq_n), .irq_n_o(irq_n_o), .ch_en(ch_en)
  );

  function automatic logic [1:0] want_en(input logic [7:0] v);
    if (v[2] == 1'b0) return 2'b00;
    return v[0] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [7:0] want_rd(input logic [1:0] irqn, input logic [7:0] v);
    logic [7:0] r;
    r = v & 8'h0F;
    if (!irqn[0]) r = r | 8'h10;
    if (!irqn[1]) r = r | 8'h20;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; scl = 1'b1; #HP; sda_m = 1'b0; #HP; scl = 1'b0; #HP;
  endtask
  task automatic brestart();
    sda_m = 1'b1; #HP; scl = 1'b1; #HP; sda_m = 1'b0; #HP; scl = 1'b0; #HP;
  endtask
  task automatic bstop();
    sda_m = 1'b0; #HP; scl = 1'b1; #HP; sda_m = 1'b1; #HP;
  endtask
  task automatic bit_out(input logic b);
    sda_m = b; #HP; scl = 1'b1; #HP; scl = 1'b0; #HP;
  endtask
  task automatic bit_in(output logic b);
    sda_m = 1'b1; #HP; scl = 1'b1; #HP; b = sda_line; scl = 1'b0; #HP;
  endtask
  task automatic byte_wr(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = ~b;
  endtask
  task automatic byte_rd(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(nack);
  endtask

  function automatic logic [7:0] adr(input logic rd);
    return {4'b1110, pins, rd};
  endfunction

  task automatic t_reset();
    chk("R8 ch_en", ch_en, 2'b00);
    chk("R8 sda_oe", sda_oe, 1'b0);
    chk("R7 irq idle", irq_n_o, 1'b1);
  endtask

  task automatic read_back(input logic [7:0] exp, input string req);
    logic a; logic [7:0] d;
    bstart(); byte_wr(adr(1'b1), a); byte_rd(1'b1, d);
    chk("R9 released after nack", sda_oe, 1'b0);
    bstop();
    chk(req, d, exp);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bstart(); byte_wr({4'b1110, 3'b100, 1'b0}, a);
    chk("R2 no ack", a, 1'b0);
    byte_wr(8'h04, a);
    chk("R2 data ignored", a, 1'b0);
    bstop();
    chk("R2 ch_en kept", ch_en, 2'b00);
    read_back(8'h00, "R2 stored unchanged");
  endtask

  task automatic t_single_write();
    logic a;
    bstart(); byte_wr(adr(1'b0), a);
    chk("R1 address ack", a, 1'b1);
    byte_wr(8'h04, a);
    chk("R3 data ack", a, 1'b1);
    chk("R5 no change before stop", ch_en, 2'b00);
    bstop();
    chk("R4 channel 0", ch_en, want_en(8'h04));
  endtask

  task automatic t_multi_write();
    logic a;
    bstart(); byte_wr(adr(1'b0), a);
    byte_wr(8'h01, a); byte_wr(8'h00, a); byte_wr(8'h07, a);
    chk("R5 old enables held", ch_en, 2'b01);
    bstop();
    chk("R3 R4 last byte, bit1 ignored", ch_en, want_en(8'h07));
    read_back(want_rd(irq_n, 8'h07), "R3 last byte stored");
  endtask

  task automatic t_disable();
    logic a;
    bstart(); byte_wr(adr(1'b0), a); byte_wr(8'hFA, a); bstop();
    chk("R4 bit2 clear", ch_en, want_en(8'hFA));
  endtask

  task automatic t_irq_read();
    irq_n = 2'b10; #HP;
    chk("R7 ch0 irq with enables off", irq_n_o, 1'b0);
    read_back(want_rd(irq_n, 8'hFA), "R6 flag ch0");
    irq_n = 2'b00; #HP;
    read_back(want_rd(irq_n, 8'hFA), "R6 both flags");
    irq_n = 2'b01; #HP;
    chk("R7 ch1 irq", irq_n_o, 1'b0);
    read_back(want_rd(irq_n, 8'hFA), "R6 flag ch1");
    irq_n = 2'b11; #HP;
    chk("R7 irq released", irq_n_o, 1'b1);
  endtask

  task automatic t_restart_multi_read();
    logic a; logic [7:0] d0, d1;
    bstart(); byte_wr(adr(1'b0), a); byte_wr(8'h0D, a);
    brestart(); byte_wr(adr(1'b1), a);
    chk("R10 address after restart", a, 1'b1);
    byte_rd(1'b0, d0);
    byte_rd(1'b1, d1);
    chk("R10 readback after restart", d0, want_rd(irq_n, 8'h0D));
    chk("R9 second byte after ack", d1, want_rd(irq_n, 8'h0D));
    chk("R5 restart keeps enables", ch_en, 2'b00);
    bstop();
    chk("R5 applied at stop", ch_en, want_en(8'h0D));
  endtask

  task automatic t_irq_at_stop();
    logic a;
    bstart(); byte_wr(adr(1'b0), a); byte_wr(8'h04, a);
    sda_m = 1'b0; #HP; scl = 1'b1; #HP;
    sda_m = 1'b1; irq_n = 2'b01; #HP;
    chk("R7 irq at stop", irq_n_o, 1'b0);
    chk("R5 enable at stop with irq", ch_en, want_en(8'h04));
    irq_n = 2'b11; #HP;
  endtask

  initial begin
    #(CLK_P * 20 + 2);
    rst_n = 1'b1;
    #(CLK_P * 5);
    t_reset();
    t_wrong_addr();
    t_single_write();
    t_multi_write();
    t_disable();
    t_irq_read();
    t_restart_multi_read();
    t_irq_at_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule